// File: doc/BRIEF.md
# I2C SCL Baud Rate Generator

This block produces the serial clock for an I2C master. A system clock is divided according to a programmable reload value so that the SCL high phase and the SCL low phase each last (reload+1)*2 system clock cycles. A full SCL period therefore lasts (reload+1)*4 cycles. The smallest accepted reload is 3, which gives an SCL rate of one sixteenth of the system clock.

Alongside SCL, the block emits a one-cycle tick in the last cycle of every half-period. The byte engine uses this tick to change or sample SDA. A reload below 3 is refused. When that happens, a sticky reject flag rises and SCL is released high until a legal value is taken in. A new reload value only takes effect at a half-period boundary, so changing it never shortens a phase that is already running.

The block also reports the speed grade that the active reload gives at the configured system clock frequency.

Top module: `i2c_scl_brg`

The controller is a four-state machine:
- ST_IDLE: the block is disabled and SCL is high.
- ST_HALT: a reload was rejected and SCL is high.
- ST_HIGH: SCL is driven high.
- ST_LOW: SCL is driven low.

Its transitions are:
- T_DISABLE: any state goes to ST_IDLE when enable is low.
- T_REJECT: any state goes to ST_HALT when enabled with an illegal reload.
- T_START: ST_IDLE or ST_HALT goes to ST_HIGH when enabled with a legal reload.
- T_FALL: ST_HIGH goes to ST_LOW on a tick.
- T_RISE: ST_LOW goes to ST_HIGH on a tick.

## Requirements
- R1: While running with a constant legal reload r, every SCL low phase and every SCL high phase lasts exactly 2*(r+1) system clock cycles.
- R2: tick is high for exactly one cycle, the last cycle of each SCL phase. SCL changes level at the clock edge that ends that cycle, and SCL never falls except at the edge right after a tick.
- R3: A reload of 0, 1 or 2 sets reject at the next clock edge. reject stays set for as long as the reload stays illegal, and clears at the edge where a legal reload is loaded.
- R4: While reject is set, SCL is high and tick is low. When a legal reload r is then applied with enable high, SCL stays high for one full phase of 2*(r+1) cycles before it falls.
- R5: A reload change made partway through a phase does not alter that phase. The new value governs the phases that follow.
- R6: While enable is low, SCL is high and tick is low from the next clock edge on. After enable rises with a legal reload r, SCL stays high for 2*(r+1) cycles and then falls.
- R7: rate_class reports the speed grade of the active reload r at system clock SYS_HZ, with f = SYS_HZ/(4*(r+1)). The encoding is 0 when f <= 100 kHz (standard), 1 when f <= 400 kHz (fast), 2 when f <= 1 MHz (fast-plus) and 3 otherwise (high-speed).
- R8: The minimum reload of 3 yields a 16-cycle SCL period, which is 8 cycles high and 8 cycles low.
- R9: During reset, SCL is high, tick is low, reject is low and rate_class is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high |
| reload | input | RELOAD_W | Reload value; the half-period is (reload+1)*2 cycles |
| scl | output | 1 | Generated SCL level |
| tick | output | 1 | One-cycle pulse in the last cycle of each SCL phase |
| reject | output | 1 | Sticky flag for an illegal reload |
| rate_class | output | 2 | Speed grade of the active reload |

## Verification
reject, ST_IDLE and ST_HALT all take effect one clock edge after the input that causes them, so the bench drives inputs on falling edges and checks these results at the next falling edge. The first SCL fall after enable, after a restart from reject, or after a reload change is due exactly 2*(r+1) cycles after the edge that loaded the counter. The bench counts SCL samples at falling edges and compares each count of high or low samples with that value. It also checks that tick appears on the last sample of each phase. rate_class follows the reload loaded in ST_IDLE one edge later, so it is compared only after a full measured period.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALT = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } brg_state_e;

    typedef enum logic [1:0] {
        RATE_STD   = 2'd0,
        RATE_FAST  = 2'd1,
        RATE_FPLUS = 2'd2,
        RATE_HS    = 2'd3
    } rate_class_e;

    localparam int unsigned MIN_RELOAD = 3;

endpackage

// File: rtl/brg_guard.sv
module brg_guard
    import brg_pkg::*;
#(
    parameter int unsigned RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                load_now,
    output logic                legal,
    output logic                reject
);

    assign legal = (reload >= RELOAD_W'(MIN_RELOAD));

    // Sticky flag: set by any illegal value, cleared only when a legal value is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject <= 1'b0;
        end else if (!legal) begin
            reject <= 1'b1;
        end else if (load_now) begin
            reject <= 1'b0;
        end
    end

endmodule

// File: rtl/brg_halfcnt.sv
module brg_halfcnt
    import brg_pkg::*;
#(
    parameter int unsigned RELOAD_W = 8,
    parameter int unsigned SYS_HZ   = 64_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                running,
    input  logic                legal,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick,
    output logic                load_now,
    output logic [1:0]          rate_class
);

    localparam int unsigned CNT_W    = RELOAD_W + 1;
    // Smallest value of (reload+1) that keeps the SCL rate at or below each grade limit.
    localparam int unsigned DIV_STD  = (SYS_HZ + 400_000 - 1) / 400_000;
    localparam int unsigned DIV_FAST = (SYS_HZ + 1_600_000 - 1) / 1_600_000;
    localparam int unsigned DIV_FP   = (SYS_HZ + 4_000_000 - 1) / 4_000_000;

    logic [CNT_W-1:0]    cnt;
    logic [RELOAD_W-1:0] active;
    logic [31:0]         div_n;

    assign tick     = running && (cnt == '0);
    assign load_now = legal && (!running || tick);

    // The counter starts at 2*(reload+1)-1, so each phase spans 2*(reload+1) cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (load_now) begin
            cnt <= {reload, 1'b1};
        end else if (running && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '1;
        end else if (load_now) begin
            active <= reload;
        end
    end

    assign div_n = 32'(active) + 32'd1;

    always_comb begin
        if (div_n >= DIV_STD) begin
            rate_class = RATE_STD;
        end else if (div_n >= DIV_FAST) begin
            rate_class = RATE_FAST;
        end else if (div_n >= DIV_FP) begin
            rate_class = RATE_FPLUS;
        end else begin
            rate_class = RATE_HS;
        end
    end

endmodule

// File: rtl/brg_fsm.sv
module brg_fsm
    import brg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       legal,
    input  logic       tick,
    output brg_state_e state,
    output logic       running,
    output logic       scl
);

    brg_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;                     // T_DISABLE
        end else if (!legal) begin
            state_nx = ST_HALT;                     // T_REJECT
        end else begin
            unique case (state)
                ST_IDLE, ST_HALT: state_nx = ST_HIGH;                   // T_START
                ST_HIGH:          state_nx = tick ? ST_LOW  : ST_HIGH;  // T_FALL
                ST_LOW:           state_nx = tick ? ST_HIGH : ST_LOW;   // T_RISE
                default:          state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_HIGH: begin running = 1'b1; scl = 1'b1; end
            ST_LOW:  begin running = 1'b1; scl = 1'b0; end
            default: begin running = 1'b0; scl = 1'b1; end
        endcase
    end

endmodule

// File: rtl/i2c_scl_brg.sv
module i2c_scl_brg
    import brg_pkg::*;
#(
    parameter int unsigned RELOAD_W = 8,
    parameter int unsigned SYS_HZ   = 64_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [RELOAD_W-1:0] reload,
    output logic                scl,
    output logic                tick,
    output logic                reject,
    output logic [1:0]          rate_class
);

    brg_state_e state;
    logic       running;
    logic       legal;
    logic       load_now;

    brg_guard #(.RELOAD_W(RELOAD_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .load_now (load_now),
        .legal    (legal),
        .reject   (reject)
    );

    brg_halfcnt #(.RELOAD_W(RELOAD_W), .SYS_HZ(SYS_HZ)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .legal      (legal),
        .reload     (reload),
        .tick       (tick),
        .load_now   (load_now),
        .rate_class (rate_class)
    );

    brg_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .legal   (legal),
        .tick    (tick),
        .state   (state),
        .running (running),
        .scl     (scl)
    );

endmodule

// File: rtl/i2c_scl_brg_chk.sv
module i2c_scl_brg_chk #(
    parameter int unsigned RELOAD_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [RELOAD_W-1:0] reload,
    input logic                scl,
    input logic                tick,
    input logic                reject
);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                            // R2

    AST_FALL_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> $past(tick));                                // R2

    AST_ILLEGAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reload < RELOAD_W'(3)) |=> reject);                        // R3

    AST_REJECT_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (scl && !tick));                                 // R4

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl && !tick));                                // R6

endmodule

bind i2c_scl_brg i2c_scl_brg_chk #(.RELOAD_W(RELOAD_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .reload (reload),
    .scl    (scl),
    .tick   (tick),
    .reject (reject)
);

// File: tb/i2c_scl_brg_test.sv
module i2c_scl_brg_test;

    localparam int          RW     = 8;
    localparam int unsigned SYS_HZ = 64_000_000;
    localparam int          LIMIT  = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [RW-1:0] reload = RW'(20);
    logic          scl, tick, reject;
    logic [1:0]    rate_class;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    i2c_scl_brg #(.RELOAD_W(RW), .SYS_HZ(SYS_HZ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .reload     (reload),
        .scl        (scl),
        .tick       (tick),
        .reject     (reject),
        .rate_class (rate_class)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_class(int r);
        real hz;
        hz = real'(SYS_HZ) / (4.0 * real'(r + 1));
        if (hz <= 100000.0)       return 0;
        else if (hz <= 400000.0)  return 1;
        else if (hz <= 1000000.0) return 2;
        else                      return 3;
    endfunction

    // Counts consecutive samples at falling edges while scl equals lvl.
    // The caller has already seen 'first' such samples. It also reports the
    // number of ticks seen in the phase and the tick on its last sample.
    task automatic count_phase(logic lvl, int first, output int len,
                               output int ticks, output logic last_tick);
        len = first;
        ticks = 0;
        last_tick = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (scl !== lvl) break;
            len++;
            ticks += int'(tick);
            last_tick = tick;
        end
    endtask

    // Counts the samples in the current phase (current sample included) and
    // counts ticks, including the one on the current sample.
    task automatic phase_from_here(logic lvl, output int len, output int ticks,
                                   output logic last_tick);
        int t0;
        logic l0;
        t0 = int'(tick);
        l0 = tick;
        count_phase(lvl, 1, len, ticks, last_tick);
        ticks += t0;
        if (len == 1) last_tick = l0;
    endtask

    task automatic measure(int r, string tag);
        int len, tk, h;
        logic lt;
        h = 2 * (r + 1);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reload = RW'(r);
        enable = 1'b1;
        count_phase(1'b1, 0, len, tk, lt);
        check_eq("R6", {tag, " first high after enable"}, len, h);
        check_eq("R2", {tag, " tick on last high sample"}, int'(lt), 1);
        check_eq("R2", {tag, " ticks in first high"}, tk, 1);
        phase_from_here(1'b0, len, tk, lt);
        check_eq("R1", {tag, " low width"}, len, h);
        check_eq("R2", {tag, " ticks in low"}, tk, 1);
        phase_from_here(1'b1, len, tk, lt);
        check_eq("R1", {tag, " high width"}, len, h);
        check_eq("R7", {tag, " rate class"}, int'(rate_class), exp_class(r));
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len, tk, h;
        logic lt;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check_eq("R9", "reset scl", int'(scl), 1);
        check_eq("R9", "reset tick", int'(tick), 0);
        check_eq("R9", "reset reject", int'(reject), 0);
        check_eq("R9", "reset rate_class", int'(rate_class), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: the minimum reload gives 8 + 8 cycles
        measure(3, "R8 r=3");
        measure(10, "r=10");
        measure(159, "r=159");
        measure(39, "r=39");
        measure(15, "r=15");
        for (int k = 0; k < 5; k++) begin
            measure(3 + int'($urandom_range(0, 60)), "random");
        end

        // R3 / R4: an illegal reload while running
        reload = RW'(5);
        @(negedge clk);
        reload = RW'($urandom_range(0, 2));
        @(negedge clk);
        check_eq("R3", "reject after illegal", int'(reject), 1);
        check_eq("R4", "scl high on reject", int'(scl), 1);
        tk = 0;
        len = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tk += int'(tick);
            len += int'(scl);
            check_eq("R3", "reject sticky", int'(reject), 1);
        end
        check_eq("R4", "no ticks while rejected", tk, 0);
        check_eq("R4", "scl high while rejected", len, 6);
        reload = RW'(4);
        @(negedge clk);
        check_eq("R3", "reject cleared on legal load", int'(reject), 0);
        phase_from_here(1'b1, len, tk, lt);
        check_eq("R4", "full high after restart", len, 10);

        // R3 while disabled
        enable = 1'b0;
        reload = RW'(2);
        @(negedge clk);
        check_eq("R3", "reject while disabled", int'(reject), 1);
        check_eq("R6", "scl high while disabled", int'(scl), 1);

        // R5: a reload change in the middle of a low phase
        reload = RW'(10);
        @(negedge clk);
        enable = 1'b1;
        count_phase(1'b1, 0, len, tk, lt);
        @(negedge clk);
        @(negedge clk);
        reload = RW'(4);
        count_phase(1'b0, 3, len, tk, lt);
        check_eq("R5", "low phase keeps old reload", len, 22);
        phase_from_here(1'b1, len, tk, lt);
        check_eq("R5", "next high uses new reload", len, 10);
        phase_from_here(1'b0, len, tk, lt);
        check_eq("R5", "next low uses new reload", len, 10);

        // R6: disabling while running
        enable = 1'b0;
        tk = 0;
        h = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            tk += int'(tick);
            h += int'(scl);
        end
        check_eq("R6", "ticks while disabled", tk, 0);
        check_eq("R6", "scl high samples while disabled", h, 20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule